// File: doc/BRIEF.md
# Split-Fill Miss Holding Register

This block keeps track of outstanding last-level cache misses when every 64-byte line is stored in two pieces on two separate memory channels. Word 0 of the line lives on a fast, narrow channel and carries one parity bit per byte. Words 1 to 7 and the eight SECDED check bytes (one per word) live on a slow, wide channel. For each accepted miss the block reserves an entry and, in the same cycle, sends one request to each channel controller tagged with the entry index.

The two halves come back in either order and are parked in the entry. If the requester asked for word 0 and all byte parities of the arriving word are good, the word is passed straight back on the critical-word port. Everything else is delivered with the line. Once both halves are held, the line goes through per-word SECDED correction and is presented on the fill port for one cycle, and the entry is released. If a word that was already passed back early turns out to have an uncorrectable error, a fatal error pulse names the entry.

Top module: `split_fill_mshr`

## Requirements
- R1: A miss with `miss_valid` high while `miss_full` is low is accepted in that cycle. The lowest free entry is allocated, and in the same cycle both `fast_req_valid` and `slow_req_valid` are high, carrying that index and `miss_addr`.
- R2: While all entries are in use, `miss_full` is high, a presented miss is refused, and neither request strobe is raised.
- R3: A fast response for a valid entry whose requested word is 0 is released early when the line's slow half is neither held nor arriving in the same cycle and every byte parity checks. Even parity applies: `fast_rsp_par[b]` equals the XOR of data bits 8b+7..8b. In that case `crit_valid` is high in the following cycle with the entry index and the word exactly as received.
- R4: If any byte parity of word 0 fails, no early release occurs. `fill_fwd` is high on the fill, and `fill_word` carries the SECDED-corrected word 0.
- R5: When the requested word is 1 to 7, it is never released early. It appears on `fill_word` with `fill_fwd` high, after correction.
- R6: The fill is presented in the cycle after the second half of the line has been stored, whichever half came first. It lasts one cycle, and the entry becomes free at the following edge.
- R7: `fill_line` holds word w at bits 64w+63..64w. Byte w of `slow_rsp_ecc` is the check byte of word w: bits 6..0 are Hamming checks over data placed at non-power-of-two positions 3,5,6,7,9,... in order, and bit 7 is even parity over the 64 data bits and the 7 check bits. Any single-bit error in any word is corrected in `fill_line` and `fill_word`.
- R8: A double-bit error in any word raises `fill_ue`. If that word is word 0 and it was released early, `fatal_valid` pulses with the fill, and `fatal_idx` names the entry. Otherwise `fatal_valid` stays low.
- R9: When both halves of a line arrive in the same cycle, there is no early release. The requested word goes out with the fill.
- R10: When several entries hold complete lines, one fill is presented per cycle, starting with the lowest index.
- R11: After reset there are no busy entries, and `miss_full`, `crit_valid`, `fill_valid` and `fatal_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | New last-level miss |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_word | input | 3 | Index of the requested word |
| miss_full | output | 1 | All entries busy; miss refused |
| fast_req_valid | output | 1 | Request to the low-latency controller |
| fast_req_idx | output | IDX_W | Entry index for the fast request |
| fast_req_addr | output | ADDR_W | Line address for the fast request |
| slow_req_valid | output | 1 | Request to the low-power controller |
| slow_req_idx | output | IDX_W | Entry index for the slow request |
| slow_req_addr | output | ADDR_W | Line address for the slow request |
| fast_rsp_valid | input | 1 | Word 0 returned |
| fast_rsp_idx | input | IDX_W | Entry the word 0 belongs to |
| fast_rsp_data | input | 64 | Word 0 data |
| fast_rsp_par | input | 8 | Per-byte even parity of word 0 |
| slow_rsp_valid | input | 1 | Words 1 to 7 and check bytes returned |
| slow_rsp_idx | input | IDX_W | Entry the slow half belongs to |
| slow_rsp_data | input | 448 | Words 1 to 7; word w at bits 64(w-1)+63..64(w-1) |
| slow_rsp_ecc | input | 64 | SECDED check byte per word, byte w for word w |
| crit_valid | output | 1 | Early release of word 0 |
| crit_idx | output | IDX_W | Entry of the early word |
| crit_data | output | 64 | Early word as received |
| fill_valid | output | 1 | Cache fill strobe |
| fill_idx | output | IDX_W | Entry being filled and freed |
| fill_addr | output | ADDR_W | Line address of the fill |
| fill_line | output | 512 | Corrected line |
| fill_ue | output | 1 | Uncorrectable error in some word |
| fill_fwd | output | 1 | Requested word is delivered now on fill_word |
| fill_word | output | 64 | Corrected requested word |
| fatal_valid | output | 1 | Early-released word found uncorrectable |
| fatal_idx | output | IDX_W | Entry of the fatal error |

## Verification
The two events that can meet in one edge are the arrival of word 0, which may trigger an early release, and the arrival of the slow half of the same line, which completes it. The bench drives both responses for one entry in the same cycle. It then expects `crit_valid` to stay low and the requested word to come out on the fill with `fill_fwd` high. It also completes two different entries in one edge, one through each channel, and judges that their fills come out on consecutive cycles, lowest index first.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int WORD_W = 64;
  localparam int LINE_WORDS = 8;
  localparam int CHK_W = 8;

  typedef struct packed {
    logic        ue;
    logic [63:0] data;
  } fix_t;

  // codeword position of data bit d (skips power-of-two positions)
  function automatic logic [6:0] data_pos(input int unsigned d);
    int unsigned n;
    logic [6:0]  res;
    n = 0;
    res = '0;
    for (int unsigned p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == d) res = 7'(p);
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [7:0] chk_gen(input logic [63:0] d);
    logic [6:0] c;
    c = '0;
    for (int unsigned i = 0; i < 64; i++)
      if (d[i]) c ^= data_pos(i);
    return {(^d) ^ (^c), c};
  endfunction

  function automatic logic par_good(input logic [63:0] d, input logic [7:0] p);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 8; b++)
      if ((^d[b*8 +: 8]) != p[b]) ok = 1'b0;
    return ok;
  endfunction

  function automatic fix_t secded_fix(input logic [63:0] d, input logic [7:0] c);
    fix_t       r;
    logic [6:0] syn;
    logic       odd;
    logic       hit;
    syn = chk_gen(d)[6:0] ^ c[6:0];
    odd = (^d) ^ (^c);
    r.data = d;
    r.ue = 1'b0;
    hit = 1'b0;
    if (odd) begin
      for (int unsigned i = 0; i < 64; i++)
        if (data_pos(i) == syn) begin
          r.data[i] = ~d[i];
          hit = 1'b1;
        end
      // syndrome pointing at no position: more than one bit bad
      if (!hit && syn != 7'd0 && (syn & (syn - 7'd1)) != 7'd0) r.ue = 1'b1;
    end else if (syn != 7'd0) begin
      r.ue = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/pick_first.sv
module pick_first #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) begin
        found = 1'b1;
        idx = IW'(i);
      end
  end
endmodule

// File: rtl/secded_word.sv
module secded_word
  import mshr_pkg::*;
(
  input  logic [63:0] din,
  input  logic [7:0]  chk,
  output logic [63:0] dout,
  output logic        ue
);
  fix_t res;
  always_comb begin
    res = secded_fix(din, chk);
    dout = res.data;
    ue = res.ue;
  end
endmodule

// File: rtl/split_fill_mshr.sv
module split_fill_mshr
  import mshr_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W = 40,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int REST_W = WORD_W * (LINE_WORDS - 1),
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int ECCS_W = CHK_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [2:0]        miss_word,
  output logic              miss_full,
  output logic              fast_req_valid,
  output logic [IDX_W-1:0]  fast_req_idx,
  output logic [ADDR_W-1:0] fast_req_addr,
  output logic              slow_req_valid,
  output logic [IDX_W-1:0]  slow_req_idx,
  output logic [ADDR_W-1:0] slow_req_addr,
  input  logic              fast_rsp_valid,
  input  logic [IDX_W-1:0]  fast_rsp_idx,
  input  logic [63:0]       fast_rsp_data,
  input  logic [7:0]        fast_rsp_par,
  input  logic              slow_rsp_valid,
  input  logic [IDX_W-1:0]  slow_rsp_idx,
  input  logic [REST_W-1:0] slow_rsp_data,
  input  logic [ECCS_W-1:0] slow_rsp_ecc,
  output logic              crit_valid,
  output logic [IDX_W-1:0]  crit_idx,
  output logic [63:0]       crit_data,
  output logic              fill_valid,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_ue,
  output logic              fill_fwd,
  output logic [63:0]       fill_word,
  output logic              fatal_valid,
  output logic [IDX_W-1:0]  fatal_idx
);
  // per-entry state
  logic [ENTRIES-1:0] vld_q, fast_q, slow_q, fwd_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [2:0]         rword_q [ENTRIES];
  logic [63:0]        w0_q [ENTRIES];
  logic [REST_W-1:0]  rest_q [ENTRIES];
  logic [ECCS_W-1:0]  ecc_q [ENTRIES];

  // named internal events
  logic              free_found, accept;
  logic [IDX_W-1:0]  alloc_idx;
  logic              fast_hit, slow_hit, early_fire, w0_par_ok;
  logic [ENTRIES-1:0] ready;

  pick_first #(.N(ENTRIES)) u_free (.req(~vld_q), .found(free_found), .idx(alloc_idx));
  pick_first #(.N(ENTRIES)) u_done (.req(ready), .found(fill_valid), .idx(fill_idx));

  assign miss_full = ~free_found;
  assign accept = miss_valid & free_found;
  assign fast_req_valid = accept;
  assign fast_req_idx = alloc_idx;
  assign fast_req_addr = miss_addr;
  assign slow_req_valid = accept;
  assign slow_req_idx = alloc_idx;
  assign slow_req_addr = miss_addr;

  assign ready = vld_q & fast_q & slow_q;
  assign fast_hit = fast_rsp_valid & vld_q[fast_rsp_idx] & ~fast_q[fast_rsp_idx];
  assign slow_hit = slow_rsp_valid & vld_q[slow_rsp_idx] & ~slow_q[slow_rsp_idx];
  assign w0_par_ok = par_good(fast_rsp_data, fast_rsp_par);
  assign early_fire = fast_hit && rword_q[fast_rsp_idx] == 3'd0 && w0_par_ok &&
                      !slow_q[fast_rsp_idx] && !(slow_hit && slow_rsp_idx == fast_rsp_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      fast_q <= '0;
      slow_q <= '0;
      fwd_q <= '0;
      crit_valid <= 1'b0;
    end else begin
      crit_valid <= early_fire;
      if (accept) begin
        vld_q[alloc_idx] <= 1'b1;
        fast_q[alloc_idx] <= 1'b0;
        slow_q[alloc_idx] <= 1'b0;
        fwd_q[alloc_idx] <= 1'b0;
      end
      if (fast_hit) begin
        fast_q[fast_rsp_idx] <= 1'b1;
        fwd_q[fast_rsp_idx] <= early_fire;
      end
      if (slow_hit) slow_q[slow_rsp_idx] <= 1'b1;
      if (fill_valid) vld_q[fill_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[alloc_idx] <= miss_addr;
      rword_q[alloc_idx] <= miss_word;
    end
    if (fast_hit) w0_q[fast_rsp_idx] <= fast_rsp_data;
    if (slow_hit) begin
      rest_q[slow_rsp_idx] <= slow_rsp_data;
      ecc_q[slow_rsp_idx] <= slow_rsp_ecc;
    end
    crit_idx <= fast_rsp_idx;
    crit_data <= fast_rsp_data;
  end

  // correction of the completed line
  logic [63:0] raw_w [LINE_WORDS];
  logic [63:0] fix_w [LINE_WORDS];
  logic [LINE_WORDS-1:0] ue_w;

  generate
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      if (w == 0) begin : g_fast
        assign raw_w[w] = w0_q[fill_idx];
      end else begin : g_slow
        assign raw_w[w] = rest_q[fill_idx][(w-1)*WORD_W +: WORD_W];
      end
      secded_word u_dec (
        .din (raw_w[w]),
        .chk (ecc_q[fill_idx][w*CHK_W +: CHK_W]),
        .dout(fix_w[w]),
        .ue  (ue_w[w])
      );
      assign fill_line[w*WORD_W +: WORD_W] = fix_w[w];
    end
  endgenerate

  assign fill_addr = addr_q[fill_idx];
  assign fill_ue = fill_valid & (|ue_w);
  assign fill_fwd = fill_valid & ~fwd_q[fill_idx];
  assign fill_word = fix_w[rword_q[fill_idx]];
  assign fatal_valid = fill_valid & fwd_q[fill_idx] & ue_w[0];
  assign fatal_idx = fill_idx;

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    fast_req_valid |-> !vld_q[fast_req_idx]); // R1
  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q == '1) |-> !(fast_req_valid || slow_req_valid)); // R2
  AST_CRIT_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> (fast_q[crit_idx] && rword_q[crit_idx] == 3'd0)); // R3
  AST_FILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !vld_q[$past(fill_idx)]); // R6
  AST_NO_DOUBLE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> !(fill_valid && fill_idx == crit_idx)); // R9
endmodule

// File: tb/sim_split_fill_mshr.sv
module sim_split_fill_mshr;
  localparam int N = 4;
  localparam int AW = 40;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic [2:0] miss_word = '0;
  logic miss_full, fast_req_valid, slow_req_valid;
  logic [IW-1:0] fast_req_idx, slow_req_idx;
  logic [AW-1:0] fast_req_addr, slow_req_addr;
  logic fast_rsp_valid = 1'b0;
  logic [IW-1:0] fast_rsp_idx = '0;
  logic [63:0] fast_rsp_data = '0;
  logic [7:0] fast_rsp_par = '0;
  logic slow_rsp_valid = 1'b0;
  logic [IW-1:0] slow_rsp_idx = '0;
  logic [447:0] slow_rsp_data = '0;
  logic [63:0] slow_rsp_ecc = '0;
  logic crit_valid, fill_valid, fill_ue, fill_fwd, fatal_valid;
  logic [IW-1:0] crit_idx, fill_idx, fatal_idx;
  logic [63:0] crit_data, fill_word;
  logic [AW-1:0] fill_addr;
  logic [511:0] fill_line;

  split_fill_mshr #(.ENTRIES(N), .ADDR_W(AW)) u0 (.*);

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent encoder: place data in a codeword, then gather each check bit
  function automatic logic [7:0] ref_ecc(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0] e;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p < 72; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        cw[p] = d[k];
        k++;
      end
    for (int i = 0; i < 7; i++) begin
      e[i] = 1'b0;
      for (int p = 1; p < 72; p++)
        if (((p >> i) & 1) == 1) e[i] = e[i] ^ cw[p];
    end
    e[7] = (^d) ^ (^e[6:0]);
    return e;
  endfunction

  function automatic logic [7:0] ref_par(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  function automatic logic [63:0] pat(input int v, input int w);
    return {8'(v), 8'(w), 48'h5A3C_0F1E_7788} ^ (64'(v * 8 + w + 1) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  // {req_word[11:9], order[8:7] 0=fast first 1=slow first 2=together, err_word[6:4], err_bits[3:2], pad[1:0]}
  localparam logic [11:0] VEC [12] = '{
    {3'd0, 2'd0, 3'd0, 2'd0, 2'd0},
    {3'd0, 2'd1, 3'd0, 2'd0, 2'd0},
    {3'd0, 2'd2, 3'd0, 2'd0, 2'd0},
    {3'd0, 2'd0, 3'd0, 2'd1, 2'd0},
    {3'd0, 2'd0, 3'd0, 2'd2, 2'd0},
    {3'd3, 2'd0, 3'd0, 2'd0, 2'd0},
    {3'd5, 2'd1, 3'd5, 2'd1, 2'd0},
    {3'd7, 2'd0, 3'd2, 2'd1, 2'd0},
    {3'd2, 2'd0, 3'd6, 2'd2, 2'd0},
    {3'd0, 2'd1, 3'd0, 2'd2, 2'd0},
    {3'd0, 2'd0, 3'd4, 2'd1, 2'd0},
    {3'd1, 2'd2, 3'd0, 2'd0, 2'd0}
  };

  task automatic issue_miss(input logic [AW-1:0] a, input logic [2:0] w, input logic [IW-1:0] exp_idx);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr = a;
    miss_word = w;
    #1;
    check(fast_req_valid && slow_req_valid, "R1 req strobes", {62'd0, fast_req_valid, slow_req_valid}, 64'd3);
    check(fast_req_idx == exp_idx && slow_req_idx == exp_idx && fast_req_addr == a && slow_req_addr == a,
          "R1 req idx/addr", 64'(fast_req_idx), 64'(exp_idx));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!miss_full && !crit_valid && !fill_valid && !fatal_valid, "R11 reset outputs",
          {60'd0, miss_full, crit_valid, fill_valid, fatal_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!miss_full && !fill_valid && !fast_req_valid, "R11 idle after reset",
          {61'd0, miss_full, fill_valid, fast_req_valid}, 64'd0);

    for (int v = 0; v < 12; v++) begin
      logic [2:0] rw, ew;
      logic [1:0] ord, eb;
      logic [63:0] clean [8];
      logic [63:0] sent [8];
      logic [63:0] ecc;
      logic [447:0] rest;
      logic par_ok, exp_crit, exp_ue;
      logic [AW-1:0] a;
      rw = VEC[v][11:9];
      ord = VEC[v][8:7];
      ew = VEC[v][6:4];
      eb = VEC[v][3:2];
      a = AW'(40'h1000 + v * 64);
      for (int w = 0; w < 8; w++) begin
        clean[w] = pat(v, w);
        sent[w] = clean[w];
        ecc[w*8 +: 8] = ref_ecc(clean[w]);
      end
      if (eb >= 2'd1) sent[ew][8] = ~sent[ew][8];
      if (eb == 2'd2) sent[ew][9] = ~sent[ew][9];
      for (int w = 1; w < 8; w++) rest[(w-1)*64 +: 64] = sent[w];
      par_ok = (ref_par(sent[0]) == ref_par(clean[0]));
      exp_crit = (rw == 3'd0) && (ord == 2'd0) && par_ok;
      exp_ue = (eb == 2'd2);

      issue_miss(a, rw, 2'd0);
      // first part(s)
      if (ord != 2'd1) begin
        fast_rsp_valid = 1'b1;
        fast_rsp_idx = 2'd0;
        fast_rsp_data = sent[0];
        fast_rsp_par = ref_par(clean[0]);
      end
      if (ord != 2'd0) begin
        slow_rsp_valid = 1'b1;
        slow_rsp_idx = 2'd0;
        slow_rsp_data = rest;
        slow_rsp_ecc = ecc;
      end
      @(negedge clk);
      fast_rsp_valid = 1'b0;
      slow_rsp_valid = 1'b0;
      if (ord == 2'd0) begin
        // R3 R4 R5: early release only for good-parity word 0
        check(crit_valid == exp_crit, "R3/R4/R5 early release", 64'(crit_valid), 64'(exp_crit));
        if (exp_crit) check(crit_data == sent[0] && crit_idx == 2'd0, "R3 early data", crit_data, sent[0]);
        check(!fill_valid, "R6 no fill with half line", 64'(fill_valid), 64'd0);
        slow_rsp_valid = 1'b1;
        slow_rsp_data = rest;
        slow_rsp_ecc = ecc;
        @(negedge clk);
        slow_rsp_valid = 1'b0;
      end else if (ord == 2'd1) begin
        check(!fill_valid, "R6 slow half held", 64'(fill_valid), 64'd0);
        fast_rsp_valid = 1'b1;
        fast_rsp_data = sent[0];
        fast_rsp_par = ref_par(clean[0]);
        @(negedge clk);
        fast_rsp_valid = 1'b0;
        check(!crit_valid, "R5/R3 no early after slow", 64'(crit_valid), 64'd0);
      end else begin
        check(!crit_valid, "R9 no early on joint arrival", 64'(crit_valid), 64'd0);
      end
      // fill cycle
      check(fill_valid && fill_idx == 2'd0 && fill_addr == a, "R6 fill strobe", 64'(fill_valid), 64'd1);
      check(fill_ue == exp_ue, "R8 fill_ue", 64'(fill_ue), 64'(exp_ue));
      check(fatal_valid == (exp_ue && ew == 3'd0 && exp_crit), "R8 fatal", 64'(fatal_valid),
            64'(exp_ue && ew == 3'd0 && exp_crit));
      check(fill_fwd == !exp_crit, "R4/R5/R9 fill_fwd", 64'(fill_fwd), 64'(!exp_crit));
      if (!exp_ue) begin
        for (int w = 0; w < 8; w++)
          check(fill_line[w*64 +: 64] == clean[w], "R7 corrected line", fill_line[w*64 +: 64], clean[w]);
        if (!exp_crit) check(fill_word == clean[rw], "R4/R5 requested word", fill_word, clean[rw]);
      end
      @(negedge clk);
      check(!fill_valid, "R6 fill one cycle", 64'(fill_valid), 64'd0);
    end

    // R1 R2: fill every entry, then refuse
    for (int i = 0; i < N; i++) issue_miss(AW'(40'h8000 + i * 64), 3'd0, IW'(i));
    @(negedge clk);
    miss_valid = 1'b1;
    #1;
    check(miss_full, "R2 full flag", 64'(miss_full), 64'd1);
    check(!fast_req_valid && !slow_req_valid, "R2 refused miss", {62'd0, fast_req_valid, slow_req_valid}, 64'd0);
    @(negedge clk);
    miss_valid = 1'b0;

    // R10: complete entries 1 and 3 in one edge through different channels
    slow_rsp_valid = 1'b1;
    slow_rsp_idx = 2'd1;
    slow_rsp_data = '0;
    slow_rsp_ecc = '0;
    @(negedge clk);
    slow_rsp_valid = 1'b0;
    fast_rsp_valid = 1'b1;
    fast_rsp_idx = 2'd3;
    fast_rsp_data = '0;
    fast_rsp_par = '0;
    @(negedge clk);
    slow_rsp_valid = 1'b1;
    slow_rsp_idx = 2'd3;
    fast_rsp_idx = 2'd1;
    @(negedge clk);
    slow_rsp_valid = 1'b0;
    fast_rsp_valid = 1'b0;
    check(fill_valid && fill_idx == 2'd1, "R10 lowest fill first", 64'(fill_idx), 64'd1);
    @(negedge clk);
    check(fill_valid && fill_idx == 2'd3, "R10 second fill next", 64'(fill_idx), 64'd3);
    check(!miss_full, "R6 entry released", 64'(miss_full), 64'd0);
    @(negedge clk);
    check(!fill_valid, "R10 no third fill", 64'(fill_valid), 64'd0);
    issue_miss(AW'(40'h9000), 3'd2, 2'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule